// File: doc/BRIEF.md
# Modem Control Register with Diagnostic Loopback

This block holds the modem-control byte of a serial port. It drives the active-low data-terminal-ready and request-to-send pins, an active-low auxiliary output and the enable for the interrupt pin. Software writes the byte through a simple write port and reads it back through a read port.

One control bit selects a diagnostic loopback. While it is set, the external transmit pin rests at mark (high). The internal transmit stream goes straight back to the internal receive input. The external receive pin and the four modem-status pins are ignored. The four low control bits then stand in for the modem-status inputs. This lets software exercise the receive path and the modem-status interrupts without any external wiring. The block presents the effective modem-status values active high, and it raises a one-cycle change flag whenever any of them moves.

Top module: `mdmctl_loop`

## Requirements
- R1: While `rst` is high at a clock edge, the register clears to zero. After reset, `rd_data` is 0, `dtr_n_pin` and `rts_n_pin` are 1, `aux_n_pin` is 1 and `irq_oe` is 0.
- R2: A write with `wr_en` high loads the register at the next rising edge. From then on `dtr_n_pin` equals the inverse of bit 0.
- R3: After a write, `rts_n_pin` equals the inverse of bit 1.
- R4: After a write, `aux_n_pin` equals the inverse of bit 2 and `irq_oe` equals bit 3. A 0 in bit 3 means the interrupt pin is in high impedance.
- R5: `rd_data[4:0]` returns bits 4..0 of the last write. `rd_data[7:5]` always reads 0 whatever was written. With `wr_en` low, the register keeps its value.
- R6: With bit 4 = 0 (normal mode), `tx_pin` follows `ser_tx_int` and `ser_rx_int` follows `rx_pin`. `mst_eff` is the inverse of `mdm_n_pin`, with the bit order 0 = CTS, 1 = DSR, 2 = RI and 3 = CD.
- R7: With bit 4 = 1 (loopback), `tx_pin` is 1 and `ser_rx_int` follows `ser_tx_int`. `rx_pin` has no effect.
- R8: In loopback, `mst_eff` takes its bits from the register: CTS = bit 1, DSR = bit 0, RI = bit 2 and CD = bit 3. `mdm_n_pin` has no effect.
- R9: `mst_change` is high during a cycle exactly when `mst_eff` differs from the value it had at the previous rising edge. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value, bits 7..5 read as zero |
| ser_tx_int | input | 1 | Internal transmit serial stream |
| tx_pin | output | 1 | External transmit pin |
| rx_pin | input | 1 | External receive pin |
| ser_rx_int | output | 1 | Internal receive serial stream |
| mdm_n_pin | input | 4 | Active-low modem-status pins (0 CTS, 1 DSR, 2 RI, 3 CD) |
| dtr_n_pin | output | 1 | Active-low data-terminal-ready pin |
| rts_n_pin | output | 1 | Active-low request-to-send pin |
| aux_n_pin | output | 1 | Active-low auxiliary output |
| irq_oe | output | 1 | Interrupt pin output enable |
| mst_eff | output | 4 | Effective modem-status values, active high |
| mst_change | output | 1 | High while any effective status differs from its previous-edge value |

## Verification
The assertions assume that the external pins and the internal transmit stream change only between rising edges. Under that assumption, the value sampled at an edge is the value that the combinational paths and the change detector used. The stimulus meets this by driving every input on the falling edge or one nanosecond after the rising edge, and never at the rising edge itself. The assertions also take the read port as a true image of the register. The bench confirms this separately, using expected values it computes for each write.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int MST_N   = 4;
    localparam int MST_CTS = 0;
    localparam int MST_DSR = 1;
    localparam int MST_RI  = 2;
    localparam int MST_CD  = 3;

    // Control byte image, packed so that dtr sits in bit 0 and loop in bit 4.
    typedef struct packed {
        logic loop;
        logic irq_en;
        logic aux;
        logic rts;
        logic dtr;
    } ctl_t;

    localparam int CTL_BITS = $bits(ctl_t);

    // Status vector presented by the register during loopback.
    function automatic logic [MST_N-1:0] loop_status(input ctl_t c);
        logic [MST_N-1:0] s;
        s          = '0;
        s[MST_CTS] = c.rts;
        s[MST_DSR] = c.dtr;
        s[MST_RI]  = c.aux;
        s[MST_CD]  = c.irq_en;
        return s;
    endfunction

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - CTL_BITS;

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= ctl_t'(wr_data[CTL_BITS-1:0]);
        end
    end

    assign ctl     = ctl_q;
    assign rd_data = {{PAD_W{1'b0}}, ctl_q};

endmodule

// File: rtl/mdm_loop_mux.sv
module mdm_loop_mux
    import mdm_pkg::*;
#(
    parameter int N = MST_N
) (
    input  ctl_t         ctl,
    input  logic         ser_tx_int,
    input  logic         rx_pin,
    input  logic [N-1:0] mdm_n_pin,
    output logic         tx_pin,
    output logic         ser_rx_int,
    output logic [N-1:0] mst_eff
);
    logic [N-1:0] lb_stat;

    assign lb_stat    = loop_status(ctl);
    assign tx_pin     = ctl.loop ? 1'b1 : ser_tx_int;
    assign ser_rx_int = ctl.loop ? ser_tx_int : rx_pin;

    for (genvar i = 0; i < N; i++) begin : g_sel
        assign mst_eff[i] = ctl.loop ? lb_stat[i] : ~mdm_n_pin[i];
    end

endmodule

// File: rtl/mdm_change_det.sv
module mdm_change_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    output logic         change
);
    logic [N-1:0] prev_q;
    logic [N-1:0] diff;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Capturing during reset too keeps the first cycle after reset quiet.
        always_ff @(posedge clk) begin
            prev_q[i] <= cur[i];
        end
        assign diff[i] = cur[i] ^ prev_q[i];
    end

    assign change = rst ? 1'b0 : |diff;

endmodule

// File: rtl/mdmctl_loop.sv
module mdmctl_loop
    import mdm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N      = MST_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ser_tx_int,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic              ser_rx_int,
    input  logic [N-1:0]      mdm_n_pin,
    output logic              dtr_n_pin,
    output logic              rts_n_pin,
    output logic              aux_n_pin,
    output logic              irq_oe,
    output logic [N-1:0]      mst_eff,
    output logic              mst_change
);
    ctl_t ctl;

    mdm_ctl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl),
        .rd_data (rd_data)
    );

    mdm_loop_mux #(.N(N)) u_mux (
        .ctl        (ctl),
        .ser_tx_int (ser_tx_int),
        .rx_pin     (rx_pin),
        .mdm_n_pin  (mdm_n_pin),
        .tx_pin     (tx_pin),
        .ser_rx_int (ser_rx_int),
        .mst_eff    (mst_eff)
    );

    mdm_change_det #(.N(N)) u_chg (
        .clk    (clk),
        .rst    (rst),
        .cur    (mst_eff),
        .change (mst_change)
    );

    assign dtr_n_pin = ~ctl.dtr;
    assign rts_n_pin = ~ctl.rts;
    assign aux_n_pin = ~ctl.aux;
    assign irq_oe    = ctl.irq_en;

endmodule

// File: rtl/mdm_loop_chk.sv
module mdm_loop_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       ser_tx_int,
    input logic       tx_pin,
    input logic       ser_rx_int,
    input logic [3:0] mdm_n_pin,
    input logic       dtr_n_pin,
    input logic       rts_n_pin,
    input logic       irq_oe,
    input logic [3:0] mst_eff,
    input logic       mst_change
);
    assert_dtr_follows_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (dtr_n_pin == ~$past(wr_data[0])));

    assert_rts_follows_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rts_n_pin == ~$past(wr_data[1])));

    assert_irq_enable_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (irq_oe == $past(wr_data[3])));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);

    assert_normal_path_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_data[4] |-> (tx_pin == ser_tx_int && mst_eff == ~mdm_n_pin));

    assert_loop_serial_R7: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (tx_pin && ser_rx_int == ser_tx_int));

    assert_loop_status_R8: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (mst_eff == {rd_data[3], rd_data[2], rd_data[0], rd_data[1]}));

    assert_change_seen_R9: assert property (@(posedge clk) disable iff (rst)
        (mst_eff != $past(mst_eff)) |-> mst_change);

    assert_change_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mst_eff == $past(mst_eff)) |-> !mst_change);

endmodule

bind mdmctl_loop mdm_loop_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .ser_tx_int (ser_tx_int),
    .tx_pin     (tx_pin),
    .ser_rx_int (ser_rx_int),
    .mdm_n_pin  (mdm_n_pin),
    .dtr_n_pin  (dtr_n_pin),
    .rts_n_pin  (rts_n_pin),
    .irq_oe     (irq_oe),
    .mst_eff    (mst_eff),
    .mst_change (mst_change)
);

// File: tb/mdmctl_loop_bench.sv
module mdmctl_loop_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ser_tx_int = 1'b0;
    logic       tx_pin;
    logic       rx_pin = 1'b0;
    logic       ser_rx_int;
    logic [3:0] mdm_n_pin = 4'hF;
    logic       dtr_n_pin, rts_n_pin, aux_n_pin, irq_oe;
    logic [3:0] mst_eff;
    logic       mst_change;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mdmctl_loop u_mdmctl_loop (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ser_tx_int(ser_tx_int), .tx_pin(tx_pin),
        .rx_pin(rx_pin), .ser_rx_int(ser_rx_int), .mdm_n_pin(mdm_n_pin),
        .dtr_n_pin(dtr_n_pin), .rts_n_pin(rts_n_pin), .aux_n_pin(aux_n_pin),
        .irq_oe(irq_oe), .mst_eff(mst_eff), .mst_change(mst_change)
    );

    // {wr[8], tx_int, rx, pins[4], exp_tx, exp_srx, exp_mst[4],
    //  exp_dtrn, exp_rtsn, exp_auxn, exp_oe, exp_rd[8]}
    localparam int NV = 9;
    localparam logic [31:0] TBL [NV] = '{
        {8'h00, 1'b1, 1'b0, 4'b1111, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        {8'h03, 1'b0, 1'b1, 4'b0101, 1'b0, 1'b1, 4'b1010, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03},
        {8'h0C, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b1, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0C},
        {8'hFF, 1'b0, 1'b1, 4'b0000, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b1, 8'h1F},
        {8'h11, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 8'h11},
        {8'h12, 1'b0, 1'b1, 4'b1111, 1'b1, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b1, 1'b0, 8'h12},
        {8'h14, 1'b1, 1'b1, 4'b1010, 1'b1, 1'b1, 4'b0100, 1'b1, 1'b1, 1'b0, 1'b0, 8'h14},
        {8'hE8, 1'b0, 1'b0, 4'b1001, 1'b0, 1'b0, 4'b0110, 1'b1, 1'b1, 1'b1, 1'b1, 8'h08},
        {8'h18, 1'b0, 1'b1, 4'b0000, 1'b1, 1'b0, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b1, 8'h18}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, with a write offered during reset
        wr_en = 1'b1; wr_data = 8'h1F;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 dtr_n/rts_n/aux_n/oe", {4'b0, dtr_n_pin, rts_n_pin, aux_n_pin, irq_oe}, 8'h0E);
        wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after release", rd_data, 8'h00);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = TBL[i];
            @(negedge clk);
            ser_tx_int = v[23];
            rx_pin = v[22];
            mdm_n_pin = v[21:18];
            do_write(v[31:24]);
            if (v[4]) begin
                chk("R7 tx/srx loop", {6'b0, tx_pin, ser_rx_int}, {6'b0, v[17:16]});
                chk("R8 mst loop", {4'b0, mst_eff}, {4'b0, v[15:12]});
            end else begin
                chk("R6 tx/srx normal", {6'b0, tx_pin, ser_rx_int}, {6'b0, v[17:16]});
                chk("R6 mst normal", {4'b0, mst_eff}, {4'b0, v[15:12]});
            end
            chk("R2 dtr_n", {7'b0, dtr_n_pin}, {7'b0, v[11]});
            chk("R3 rts_n", {7'b0, rts_n_pin}, {7'b0, v[10]});
            chk("R4 aux_n/oe", {6'b0, aux_n_pin, irq_oe}, {6'b0, v[9:8]});
            chk("R5 rd_data", rd_data, v[7:0]);
        end

        // R5: no write when wr_en is low
        @(negedge clk);
        wr_data = 8'h07;
        @(posedge clk); #1;
        chk("R5 hold without wr_en", rd_data, 8'h18);

        // R7/R8: pins ignored in loopback (reg 0x18)
        @(negedge clk);
        rx_pin = 1'b0; mdm_n_pin = 4'b1111; ser_tx_int = 1'b1;
        #1;
        chk("R7 rx ignored", {7'b0, ser_rx_int}, 8'h01);
        chk("R8 pins ignored", {4'b0, mst_eff}, 8'h08);
        chk("R8 no change from pins", {7'b0, mst_change}, 8'h00);

        // R9: loopback change via a register write
        do_write(8'h19);
        chk("R9 change on write", {7'b0, mst_change}, 8'h01);
        @(posedge clk); #1;
        chk("R9 quiet next cycle", {7'b0, mst_change}, 8'h00);

        // R9: normal-mode change from a pin
        do_write(8'h00);
        @(negedge clk);
        mdm_n_pin = 4'b1111;
        @(posedge clk); @(posedge clk); #1;
        chk("R9 stable pins quiet", {7'b0, mst_change}, 8'h00);
        @(negedge clk);
        mdm_n_pin = 4'b1011;
        #1;
        chk("R9 pin toggle flags", {7'b0, mst_change}, 8'h01);
        @(posedge clk); #1;
        chk("R9 flag clears", {7'b0, mst_change}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule